// File: doc/BRIEF.md
# Dual-Rail Serial Stream Router Tree

This block steers a serial stream of dual-rail pulses to one of sixteen leaf outputs. It is a four-level binary tree of one-to-two switches. Every switch keeps a direction bit, and that bit is loaded by a dual-rail select pulse. Passing data through a switch never changes the bit. Once a destination has been chosen, every later bit of the stream follows the same path until a new select pulse arrives at that switch.

The address arrives as one dual-rail pair per tree level. The pairs enter together with the data and move down the tree beside it. Each level uses the pair meant for it and hands the rest to the child it now selects. So a data bit that enters in the same cycle as an address already goes to the new leaf. A level whose pair is silent keeps its switch setting, which lets a stream move to a nearby leaf by resending only the lower address bits.

Each switch is built from four hold cells, one for each pairing of output and data rail. A switch is enabled only by pulses arriving at its own inputs. Each tree level adds one register stage.

A pair that pulses on both rails in the same cycle is a protocol violation. It is dropped and reported on an error pulse.

Top module: `pdt_decoder_tree`

## Requirements
- R1: After reset all leaf outputs and `rail_err` are low, and every switch selects its 0 path, so data sent with no address reaches leaf 0.
- R2: Address pair k (k = 0 is the root) chooses the path at level k, and its value is bit (3 - k) of the leaf index: a pulse on `adr_one[k]` gives 1 and a pulse on `adr_zero[k]` gives 0. A pulse on `din_one` leaves on `dout_one` of the chosen leaf, and a pulse on `din_zero` leaves on `dout_zero` of that leaf.
- R3: A data pulse shows up at its leaf exactly four clock cycles after it is presented at the input, and not in any other cycle.
- R4: Data that passes through a switch does not change the switch's selection, so later data sent without an address reaches the same leaf.
- R5: In each cycle at most one leaf pulses. A leaf pulses only because a valid data pulse was presented four cycles earlier.
- R6: A data pulse presented in the same cycle as a full address uses that new address.
- R7: A level whose address pair is silent keeps the selection held by the switch that the stream reaches at that level. The other levels still take their new bits.
- R8: If `din_one` and `din_zero` pulse in the same cycle, the data is dropped, no leaf pulses for it, and `rail_err` pulses one cycle later.
- R9: If both rails of an address pair pulse in the same cycle, that level's select is ignored, the other levels are still applied, and `rail_err` pulses one cycle later. With no clash, `rail_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_one | input | 1 | Data pulse, rail for value 1 |
| din_zero | input | 1 | Data pulse, rail for value 0 |
| adr_one | input | 4 | Per-level address pulse that selects path 1; bit k is for level k |
| adr_zero | input | 4 | Per-level address pulse that selects path 0; bit k is for level k |
| dout_one | output | 16 | Leaf data pulses, rail for value 1; bit j is leaf j |
| dout_zero | output | 16 | Leaf data pulses, rail for value 0; bit j is leaf j |
| rail_err | output | 1 | Pulses one cycle after a clash on any input pair |

## Verification
The bench keeps a per-switch model of the tree. Every cycle it compares all leaf rails and the error pulse against values the model predicts four cycles (or one cycle) ahead.

It uses these input patterns:
- **Sweep of all sixteen full addresses, each followed by a short stream.** Tells apart mistakes in bit order, rail swaps and loss of persistence.
- **Addresses that change every cycle.** Exposes a switch that routes one cycle late.
- **Random address pairs that are only partly present.** Exposes a tree that clears or shares state between sibling switches instead of keeping it per switch.
- **Injected clashes on the data pair and on single address pairs.** Separates a block that drops bad pairs from one that lets one rail win.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

  // One dual-rail symbol: exactly one rail pulses for a valid bit.
  typedef struct packed {
    logic one;
    logic zero;
  } rail_t;

  // Keep a pair only when exactly one rail fired.
  function automatic rail_t rail_accept(input logic r_one, input logic r_zero);
    rail_t r;
    r.one  = r_one & ~r_zero;
    r.zero = r_zero & ~r_one;
    return r;
  endfunction

  // Both rails of the pair fired together.
  function automatic logic rail_clash(input logic r_one, input logic r_zero);
    return r_one & r_zero;
  endfunction

  // Heap numbering of the tree: node i feeds buses 2i and 2i+1.
  function automatic int unsigned heap_child(input int unsigned node, input logic dir);
    return node * 2 + int'(dir);
  endfunction

  // Selected state after one select pair, given the prior state.
  function automatic logic sel_update(input logic held, input logic to_one, input logic to_zero);
    if (to_one)  return 1'b1;
    if (to_zero) return 1'b0;
    return held;
  endfunction

endpackage

// File: rtl/pdt_hold_cell.sv
// Non-destructive cell: keeps a selection bit and passes trigger
// pulses while selected. A trigger never alters the kept bit.
module pdt_hold_cell #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic load_on,
  input  logic load_off,
  input  logic trig,
  output logic fire,
  output logic sel_next,
  output logic held
);
  import pdt_pkg::*;

  always_comb begin
    sel_next = sel_update(held, load_on, load_off);
    fire     = trig & sel_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  held <= INIT;
    else if (en) held <= sel_next;
  end
endmodule

// File: rtl/pdt_switch_node.sv
// One-to-two switch. Bit 0 of the incoming address vector is this
// node's select pair; the rest moves on to the selected child.
module pdt_switch_node #(
  parameter int unsigned AW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  pdt_pkg::rail_t         in_d,
  input  logic [AW-1:0]          in_a_one,
  input  logic [AW-1:0]          in_a_zero,
  output pdt_pkg::rail_t [1:0]   out_d,
  output logic [1:0][AW-1:0]     out_a_one,
  output logic [1:0][AW-1:0]     out_a_zero,
  output logic                   node_evt,
  output logic                   cells_agree
);
  import pdt_pkg::*;

  logic set_p;
  logic clr_p;
  logic [1:0][1:0] fire;   // [output][rail]
  logic [1:0][1:0] nxt;
  logic [1:0][1:0] held;
  logic [1:0]      steer;

  assign set_p = in_a_one[0];
  assign clr_p = in_a_zero[0];

  // Local timing event: any rail arriving at this node.
  assign node_evt = in_d.one | in_d.zero | (|in_a_one) | (|in_a_zero);

  for (genvar c = 0; c < 2; c++) begin : g_out
    for (genvar r = 0; r < 2; r++) begin : g_rail
      logic f_w, n_w, h_w;
      pdt_hold_cell #(.INIT(c == 0 ? 1'b1 : 1'b0)) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (node_evt),
        .load_on  (c == 1 ? set_p : clr_p),
        .load_off (c == 1 ? clr_p : set_p),
        .trig     (r == 1 ? in_d.one : in_d.zero),
        .fire     (f_w),
        .sel_next (n_w),
        .held     (h_w)
      );
      assign fire[c][r] = f_w;
      assign nxt[c][r]  = n_w;
      assign held[c][r] = h_w;
    end
    assign steer[c] = nxt[c][0];
  end

  // All four cells must describe one and the same direction.
  assign cells_agree = (held[1][0] == held[1][1]) &&
                       (held[0][0] == held[0][1]) &&
                       (held[1][0] != held[0][0]) &&
                       (nxt[1][1]  == nxt[1][0])  &&
                       (nxt[0][1]  == nxt[0][0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_d      <= '0;
      out_a_one  <= '0;
      out_a_zero <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        out_d[c].one  <= fire[c][1];
        out_d[c].zero <= fire[c][0];
        out_a_one[c]  <= steer[c] ? (in_a_one  >> 1) : '0;
        out_a_zero[c] <= steer[c] ? (in_a_zero >> 1) : '0;
      end
    end
  end
endmodule

// File: rtl/pdt_decoder_tree.sv
module pdt_decoder_tree #(
  parameter int unsigned LEVELS = 4,
  localparam int unsigned LEAVES = 1 << LEVELS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din_one,
  input  logic              din_zero,
  input  logic [LEVELS-1:0] adr_one,
  input  logic [LEVELS-1:0] adr_zero,
  output logic [LEAVES-1:0] dout_one,
  output logic [LEAVES-1:0] dout_zero,
  output logic              rail_err
);
  import pdt_pkg::*;

  localparam int unsigned BUSES = 2 * LEAVES - 1;

  // Heap-indexed buses: 1 is the root input, LEAVES..BUSES are leaves.
  rail_t             bus_d  [1:BUSES];
  logic [LEVELS-1:0] bus_a1 [1:BUSES];
  logic [LEVELS-1:0] bus_a0 [1:BUSES];
  logic              node_evt [1:LEAVES-1];
  logic              node_ok  [1:LEAVES-1];

  logic              root_evt;
  logic              tree_consistent;
  logic              stray_adr;
  logic              any_clash;

  // Input cleaning: clashing pairs are dropped.
  always_comb begin
    bus_d[1]  = rail_accept(din_one, din_zero);
    any_clash = rail_clash(din_one, din_zero);
    for (int k = 0; k < LEVELS; k++) begin
      rail_t a;
      a = rail_accept(adr_one[k], adr_zero[k]);
      bus_a1[1][k] = a.one;
      bus_a0[1][k] = a.zero;
      any_clash    = any_clash | rail_clash(adr_one[k], adr_zero[k]);
    end
  end

  for (genvar i = 1; i < LEAVES; i++) begin : g_node
    rail_t [1:0]             od;
    logic  [1:0][LEVELS-1:0] oa1;
    logic  [1:0][LEVELS-1:0] oa0;
    logic                    evt_w;
    logic                    ok_w;

    pdt_switch_node #(.AW(LEVELS)) u_sw (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_d        (bus_d[i]),
      .in_a_one    (bus_a1[i]),
      .in_a_zero   (bus_a0[i]),
      .out_d       (od),
      .out_a_one   (oa1),
      .out_a_zero  (oa0),
      .node_evt    (evt_w),
      .cells_agree (ok_w)
    );

    assign bus_d[2*i]    = od[0];
    assign bus_d[2*i+1]  = od[1];
    assign bus_a1[2*i]   = oa1[0];
    assign bus_a1[2*i+1] = oa1[1];
    assign bus_a0[2*i]   = oa0[0];
    assign bus_a0[2*i+1] = oa0[1];
    assign node_evt[i]   = evt_w;
    assign node_ok[i]    = ok_w;
  end

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    assign dout_one[j]  = bus_d[LEAVES+j].one;
    assign dout_zero[j] = bus_d[LEAVES+j].zero;
  end

  assign root_evt = node_evt[1];

  always_comb begin
    tree_consistent = 1'b1;
    for (int i = 1; i < LEAVES; i++) tree_consistent = tree_consistent & node_ok[i];
    stray_adr = 1'b0;
    for (int j = 0; j < LEAVES; j++)
      stray_adr = stray_adr | (|bus_a1[LEAVES+j]) | (|bus_a0[LEAVES+j]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rail_err <= 1'b0;
    else        rail_err <= any_clash;
  end
endmodule

// File: rtl/pdt_decoder_tree_chk.sv
module pdt_decoder_tree_chk #(
  parameter int unsigned LEVELS = 4,
  localparam int unsigned LEAVES = 1 << LEVELS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              din_one,
  input logic              din_zero,
  input logic [LEVELS-1:0] adr_one,
  input logic [LEVELS-1:0] adr_zero,
  input logic [LEAVES-1:0] dout_one,
  input logic [LEAVES-1:0] dout_zero,
  input logic              rail_err,
  input logic              tree_consistent,
  input logic              stray_adr,
  input logic              root_evt
);
  // Cycles since reset release, saturating.
  logic [2:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 3'd7) warm <= warm + 3'd1;
  end

  AST_SINGLE_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dout_one | dout_zero));                                          // R5

  AST_RAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_one & dout_zero) == '0);                                            // R2

  AST_LAT_ONE_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'd5 && $past(din_one && !din_zero, 4)) |-> (|dout_one));       // R3

  AST_LAT_ZERO_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'd5 && $past(din_zero && !din_one, 4)) |-> (|dout_zero));      // R3

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'd5 && (|(dout_one | dout_zero))) |->
      $past(din_one != din_zero, 4));                                         // R5

  AST_DATA_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (din_one && din_zero) |=> rail_err);                                      // R8

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'd1 && rail_err) |->
      $past((din_one && din_zero) || (|(adr_one & adr_zero))));               // R9

  AST_CELLS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    tree_consistent);                                                         // R4

  AST_ADR_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    !stray_adr);                                                              // R7

  AST_ROOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!din_one && !din_zero && adr_one == '0 && adr_zero == '0) |-> !root_evt); // R5
endmodule

bind pdt_decoder_tree pdt_decoder_tree_chk #(.LEVELS(LEVELS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .din_one         (din_one),
  .din_zero        (din_zero),
  .adr_one         (adr_one),
  .adr_zero        (adr_zero),
  .dout_one        (dout_one),
  .dout_zero       (dout_zero),
  .rail_err        (rail_err),
  .tree_consistent (tree_consistent),
  .stray_adr       (stray_adr),
  .root_evt        (root_evt)
);

// File: tb/pdt_decoder_tree_bench.sv
module pdt_decoder_tree_bench;
  localparam int unsigned LV    = 4;
  localparam int unsigned NL    = 1 << LV;
  localparam time         CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          din_one = 1'b0, din_zero = 1'b0;
  logic [LV-1:0] adr_one = '0, adr_zero = '0;
  logic [NL-1:0] dout_one, dout_zero;
  logic          rail_err;

  pdt_decoder_tree #(.LEVELS(LV)) u_pdt_decoder_tree (
    .clk(clk), .rst_n(rst_n), .din_one(din_one), .din_zero(din_zero),
    .adr_one(adr_one), .adr_zero(adr_zero),
    .dout_one(dout_one), .dout_zero(dout_zero), .rail_err(rail_err)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // Bench model: one direction bit per switch, heap-numbered.
  logic          mdl [1:NL-1];
  logic [NL-1:0] exp1 [8];
  logic [NL-1:0] exp0 [8];
  logic          expe [8];
  string         dtag [8];
  string         etag [8];

  task automatic clear_model();
    for (int i = 1; i < NL; i++) mdl[i] = 1'b0;
    for (int s = 0; s < 8; s++) begin
      exp1[s] = '0; exp0[s] = '0; expe[s] = 1'b0;
      dtag[s] = "R5"; etag[s] = "R9";
    end
  endtask

  // One cycle: check this cycle's predictions, then drive and predict.
  task automatic step(input logic d1, input logic d0,
                      input logic [LV-1:0] a1, input logic [LV-1:0] a0,
                      input string tag);
    int s, node, leaf;
    logic clash;
    @(negedge clk);
    s = cyc % 8;
    checks++;
    if (dout_one !== exp1[s] || dout_zero !== exp0[s]) begin
      fails++;
      $display("FAIL %s cycle %0d: leaves one=%h zero=%h expected one=%h zero=%h",
               dtag[s], cyc, dout_one, dout_zero, exp1[s], exp0[s]);
    end
    checks++;
    if (rail_err !== expe[s]) begin
      fails++;
      $display("FAIL %s cycle %0d: rail_err=%b expected %b", etag[s], cyc, rail_err, expe[s]);
    end
    exp1[s] = '0; exp0[s] = '0; expe[s] = 1'b0;

    din_one = d1; din_zero = d0; adr_one = a1; adr_zero = a0;

    clash = (d1 & d0) | (|(a1 & a0));
    node = 1;
    for (int l = 0; l < int'(LV); l++) begin
      if (a1[l] && !a0[l]) mdl[node] = 1'b1;
      if (a0[l] && !a1[l]) mdl[node] = 1'b0;
      node = 2 * node + int'(mdl[node]);
    end
    leaf = node - int'(NL);
    if (d1 && !d0) exp1[(cyc+4)%8][leaf] = 1'b1;
    if (d0 && !d1) exp0[(cyc+4)%8][leaf] = 1'b1;
    dtag[(cyc+4)%8] = tag;
    expe[(cyc+1)%8] = clash;
    etag[(cyc+1)%8] = (d1 & d0) ? "R8" : "R9";
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, '0, '0, "R5");
  endtask

  // Address pairs for a full leaf index: level k carries bit (LV-1-k).
  function automatic logic [LV-1:0] leaf_bits(input int leaf);
    logic [LV-1:0] b;
    for (int k = 0; k < int'(LV); k++) b[k] = leaf[LV-1-k];
    return b;
  endfunction

  initial begin : watchdog
    #(CLK_P * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: run still busy (actual running, expected done)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [LV-1:0] b;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (dout_one !== '0 || dout_zero !== '0 || rail_err !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: one=%h zero=%h err=%b expected all 0", dout_one, dout_zero, rail_err);
    end

    // R1: no address yet, data lands on leaf 0 on the right rails
    step(1'b1, 1'b0, '0, '0, "R1");
    step(1'b0, 1'b1, '0, '0, "R1");
    idle(5);

    // R2 R3 R6 R4: every leaf, address with the first bit, then a stream
    for (int leaf = 0; leaf < int'(NL); leaf++) begin
      b = leaf_bits(leaf);
      step(1'b1, 1'b0, b, ~b, "R6");
      step(1'b0, 1'b1, '0, '0, "R4");
      step(1'b1, 1'b0, '0, '0, "R2");
      step(1'b0, 1'b0, '0, '0, "R3");
      step(1'b0, 1'b1, '0, '0, "R4");
    end
    idle(5);

    // R6: destination changes every cycle
    for (int k = 0; k < 64; k++) begin
      b = leaf_bits(int'($urandom_range(NL-1)));
      step(k[0], ~k[0], b, ~b, "R6");
    end
    idle(5);

    // R7: per-level address pairs present at random
    for (int k = 0; k < 300; k++) begin
      logic [LV-1:0] pres;
      pres = LV'($urandom);
      b    = LV'($urandom);
      step(($urandom_range(3) != 0) & k[0], ($urandom_range(3) != 0) & ~k[0],
           b & pres, ~b & pres, "R7");
    end
    idle(5);

    // R8: data clash, then a clean bit to see routing intact
    b = leaf_bits(9);
    step(1'b0, 1'b0, b, ~b, "R2");
    step(1'b1, 1'b1, '0, '0, "R8");
    step(1'b1, 1'b0, '0, '0, "R8");
    step(1'b1, 1'b1, '0, '0, "R8");
    idle(5);

    // R9: clash on single address levels, others still apply
    for (int lvl = 0; lvl < int'(LV); lvl++) begin
      logic [LV-1:0] bad;
      b   = leaf_bits(int'($urandom_range(NL-1)));
      bad = LV'(1) << lvl;
      step(1'b1, 1'b0, b | bad, ~b | bad, "R9");
      step(1'b0, 1'b1, '0, '0, "R9");
      idle(2);
    end

    // R9 and R8 mixed random with clashes
    for (int k = 0; k < 200; k++) begin
      logic [LV-1:0] x1, x0;
      x1 = LV'($urandom); x0 = LV'($urandom);
      step(1'($urandom), 1'($urandom), x1, x0, "R9");
    end
    idle(6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule